// File: doc/BRIEF.md
# Byte-Port DMA Channel Register File

This block is the host-side register file of a four-channel DMA controller. A host reaches it through a narrow 8-bit port with a 4-bit port number. The low eight port numbers carry each channel's 16-bit address and count words, one byte at a time. The byte that an access reaches is chosen by one byte-order pointer that all channels share. The upper eight port numbers hold the control functions: command, request, single-channel mask, mode, pointer clear, master clear, mask clear and the all-channel mask.

The outputs feed the channel datapaths: each channel's mode, its mask bit, its base words, its current words, the command byte and the software request bits. A per-channel `step_i` pulse from the transfer engine advances the current address and count. It reloads the current words in autoinitialize mode and records a terminal count in the status byte. The host reads the status byte back through the command port. The read data for the addressed port is always present on `bus_rdata_o`. An access takes effect at the clock edge where `bus_valid_i` is high.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel mask bit is 1, the byte pointer selects the low byte, and every word, mode, command, request and status bit is 0.
- R2: Channel n's address word is at port 2n and its count word is at port 2n+1. A byte write puts the data into the byte the pointer selects (low when the pointer is 0), and the current word takes the resulting base word in the same cycle.
- R3: Every valid read or write of ports 0x0 to 0x7 inverts the byte pointer. Accesses to ports 0x8 to 0xF leave it unchanged, except for the clears in R4 and R10.
- R4: A write of any value to port 0xC makes the pointer select the low byte.
- R5: A write to port 0xA sets channel wdata[1:0]'s mask bit to wdata[2]. No other channel's mask changes.
- R6: A write to port 0xE clears all four masks. A write to port 0xF loads the masks from wdata[3:0], where bit n is channel n.
- R7: A write to port 0xB stores wdata[7:2] as the mode of channel wdata[1:0]. In that field, wdata[3:2] is the transfer type, wdata[4] enables autoinitialize, wdata[5] selects address decrement and wdata[7:6] is the service mode (3 is cascade).
- R8: A write to port 0x9 sets the request bit of channel wdata[1:0] to wdata[2].
- R9: A write to port 0x8 loads all eight bits of the command output.
- R10: A write to port 0xD sets all masks and clears the pointer, the command, the request bits and the status flags. Modes and words keep their values.
- R11: bus_rdata_o shows the pointer-selected byte of the current address word (even port) or the current count word (odd port) for ports 0x0 to 0x7.
- R12: A step_i pulse on a channel that is not being written decrements the current count. It also moves the current address by one, up or down as the mode selects. A step at count 0 leaves the count at 0xFFFF and sets that channel's terminal-count flag.
- R13: In autoinitialize mode, a step at count 0 reloads the current address and count from the base words and still sets the flag.
- R14: Port 0x8 reads {request[3:0], terminal-count[3:0]}. A valid read of port 0x8 clears the flags, and a flag raised in the same cycle survives. Ports 0x9 to 0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe for this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_port_i | input | 4 | Port number |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read value of the addressed port |
| step_i | input | 4 | Per-channel transfer step from the engine |
| chan_mode_o | output | 24 | Six-bit mode per channel, channel n at [6n+5:6n] |
| chan_mask_o | output | 4 | Mask bit per channel |
| base_addr_o | output | 64 | Base address words, channel n at [16n+15:16n] |
| base_count_o | output | 64 | Base count words |
| cur_addr_o | output | 64 | Current address words |
| cur_count_o | output | 64 | Current count words |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Software request bits |

## Verification
The assertions take it that `step_i` and the port strobe are sampled together at the same edge. They also take it that a write to a channel's word ports in the same cycle as its step cancels the step, so the count-decrement property excludes that case. The stimulus drives every input just after a rising edge and holds it for a full cycle, so the reference model and the design see the same values. It mixes directed sequences with a long pseudo-random phase over all sixteen ports and all step patterns, including steps that collide with word writes, status reads that coincide with terminal counts, and master clears.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned NUM_CH  = 1 << CH_W;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned PORT_W  = 4;
  localparam int unsigned MODE_W  = BYTE_W - CH_W;
  localparam int unsigned FLAG_B  = 2;              // wdata bit carrying set/clear
  localparam int unsigned MODE_AUTO = 4 - CH_W;     // autoinit bit within stored mode
  localparam int unsigned MODE_DEC  = 5 - CH_W;     // decrement bit within stored mode

  typedef enum logic [PORT_W-1:0] {
    P_CMD     = 4'h8,
    P_REQ     = 4'h9,
    P_SMASK   = 4'hA,
    P_MODE    = 4'hB,
    P_CLRPTR  = 4'hC,
    P_MCLR    = 4'hD,
    P_CLRMASK = 4'hE,
    P_AMASK   = 4'hF
  } ctl_port_e;

  typedef struct packed {
    logic cmd_wr;
    logic req_wr;
    logic smask_wr;
    logic mode_wr;
    logic clrptr_wr;
    logic mclr_wr;
    logic clrmask_wr;
    logic amask_wr;
    logic stat_rd;
    logic chan_acc;
  } strobe_t;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [PORT_W-1:0] port_i,
  output strobe_t           strobe_o,
  output logic [NUM_CH-1:0] addr_wr_o,
  output logic [NUM_CH-1:0] cnt_wr_o
);
  logic is_chan;
  assign is_chan = valid_i && !port_i[PORT_W-1];

  always_comb begin
    strobe_o = '0;
    strobe_o.chan_acc = is_chan;
    if (valid_i && write_i) begin
      case (port_i)
        P_CMD:     strobe_o.cmd_wr     = 1'b1;
        P_REQ:     strobe_o.req_wr     = 1'b1;
        P_SMASK:   strobe_o.smask_wr   = 1'b1;
        P_MODE:    strobe_o.mode_wr    = 1'b1;
        P_CLRPTR:  strobe_o.clrptr_wr  = 1'b1;
        P_MCLR:    strobe_o.mclr_wr    = 1'b1;
        P_CLRMASK: strobe_o.clrmask_wr = 1'b1;
        P_AMASK:   strobe_o.amask_wr   = 1'b1;
        default: ;
      endcase
    end
    if (valid_i && !write_i && port_i == P_CMD) strobe_o.stat_rd = 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan_dec
    logic hit;
    assign hit          = is_chan && write_i && (port_i[CH_W:1] == CH_W'(g));
    assign addr_wr_o[g] = hit && !port_i[0];
    assign cnt_wr_o[g]  = hit && port_i[0];
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic              hi_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] base_addr_o,
  output logic [WORD_W-1:0] base_cnt_o,
  output logic [WORD_W-1:0] cur_addr_o,
  output logic [WORD_W-1:0] cur_cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              tc_o
);
  logic [WORD_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic [WORD_W-1:0] new_addr, new_cnt, addr_adv;
  logic              step_en, wrap;

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] b);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

  assign new_addr = put_byte(base_addr_q, hi_sel_i, wdata_i);
  assign new_cnt  = put_byte(base_cnt_q, hi_sel_i, wdata_i);
  // a word write in the same cycle cancels the step
  assign step_en  = step_i && !addr_wr_i && !cnt_wr_i;
  assign wrap     = step_en && (cur_cnt_q == '0);
  assign addr_adv = mode_q[MODE_DEC] ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
    end else begin
      if (mode_wr_i) mode_q <= mode_i;
      if (addr_wr_i) begin
        base_addr_q <= new_addr;
        cur_addr_q  <= new_addr;
      end
      if (cnt_wr_i) begin
        base_cnt_q <= new_cnt;
        cur_cnt_q  <= new_cnt;
      end
      if (step_en) begin
        if (wrap && mode_q[MODE_AUTO]) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          cur_addr_q <= addr_adv;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
      end
    end
  end

  assign base_addr_o = base_addr_q;
  assign base_cnt_o  = base_cnt_q;
  assign cur_addr_o  = cur_addr_q;
  assign cur_cnt_o   = cur_cnt_q;
  assign mode_o      = mode_q;
  assign tc_o        = wrap;
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           strobe_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] tc_i,
  output logic              ptr_hi_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] tc_stat_o
);
  logic              ptr_q;
  logic [NUM_CH-1:0] mask_q, req_q, tc_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [CH_W-1:0]   sel;
  logic              tc_clr;

  assign sel    = wdata_i[CH_W-1:0];
  assign tc_clr = strobe_i.mclr_wr || strobe_i.stat_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      if (strobe_i.mclr_wr || strobe_i.clrptr_wr) ptr_q <= 1'b0;
      else if (strobe_i.chan_acc)                 ptr_q <= ~ptr_q;

      if (strobe_i.mclr_wr)         mask_q      <= '1;
      else if (strobe_i.smask_wr)   mask_q[sel] <= wdata_i[FLAG_B];
      else if (strobe_i.clrmask_wr) mask_q      <= '0;
      else if (strobe_i.amask_wr)   mask_q      <= wdata_i[NUM_CH-1:0];

      if (strobe_i.mclr_wr)      req_q      <= '0;
      else if (strobe_i.req_wr)  req_q[sel] <= wdata_i[FLAG_B];

      if (strobe_i.mclr_wr)      cmd_q <= '0;
      else if (strobe_i.cmd_wr)  cmd_q <= wdata_i;

      // a flag raised this cycle outlives a clear
      tc_q <= (tc_clr ? '0 : tc_q) | tc_i;
    end
  end

  assign ptr_hi_o  = ptr_q;
  assign mask_o    = mask_q;
  assign cmd_o     = cmd_q;
  assign req_o     = req_q;
  assign tc_stat_o = tc_q;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic                       bus_write_i,
  input  logic [PORT_W-1:0]          bus_port_i,
  input  logic [BYTE_W-1:0]          bus_wdata_i,
  output logic [BYTE_W-1:0]          bus_rdata_o,
  input  logic [NUM_CH-1:0]          step_i,
  output logic [NUM_CH*MODE_W-1:0]   chan_mode_o,
  output logic [NUM_CH-1:0]          chan_mask_o,
  output logic [NUM_CH*WORD_W-1:0]   base_addr_o,
  output logic [NUM_CH*WORD_W-1:0]   base_count_o,
  output logic [NUM_CH*WORD_W-1:0]   cur_addr_o,
  output logic [NUM_CH*WORD_W-1:0]   cur_count_o,
  output logic [BYTE_W-1:0]          cmd_o,
  output logic [NUM_CH-1:0]          req_o
);
  strobe_t           strobe;
  logic [NUM_CH-1:0] addr_wr, cnt_wr, tc, tc_stat;
  logic              ptr_hi;

  dma_rf_decode u_decode (
    .valid_i  (bus_valid_i),
    .write_i  (bus_write_i),
    .port_i   (bus_port_i),
    .strobe_o (strobe),
    .addr_wr_o(addr_wr),
    .cnt_wr_o (cnt_wr)
  );

  dma_rf_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .wdata_i  (bus_wdata_i),
    .tc_i     (tc),
    .ptr_hi_o (ptr_hi),
    .mask_o   (chan_mask_o),
    .cmd_o    (cmd_o),
    .req_o    (req_o),
    .tc_stat_o(tc_stat)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic mode_hit;
    assign mode_hit = strobe.mode_wr && (bus_wdata_i[CH_W-1:0] == CH_W'(g));
    dma_rf_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_wr_i  (addr_wr[g]),
      .cnt_wr_i   (cnt_wr[g]),
      .hi_sel_i   (ptr_hi),
      .wdata_i    (bus_wdata_i),
      .mode_wr_i  (mode_hit),
      .mode_i     (bus_wdata_i[BYTE_W-1:CH_W]),
      .step_i     (step_i[g]),
      .base_addr_o(base_addr_o[g*WORD_W +: WORD_W]),
      .base_cnt_o (base_count_o[g*WORD_W +: WORD_W]),
      .cur_addr_o (cur_addr_o[g*WORD_W +: WORD_W]),
      .cur_cnt_o  (cur_count_o[g*WORD_W +: WORD_W]),
      .mode_o     (chan_mode_o[g*MODE_W +: MODE_W]),
      .tc_o       (tc[g])
    );
  end

  logic [CH_W-1:0]   rd_ch;
  logic [WORD_W-1:0] rd_word;
  assign rd_ch   = bus_port_i[CH_W:1];
  assign rd_word = bus_port_i[0] ? cur_count_o[rd_ch*WORD_W +: WORD_W]
                                 : cur_addr_o[rd_ch*WORD_W +: WORD_W];

  always_comb begin
    bus_rdata_o = '0;
    if (!bus_port_i[PORT_W-1])
      bus_rdata_o = ptr_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    else if (bus_port_i == P_CMD)
      bus_rdata_o = {req_o, tc_stat};
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_rf_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic                     write_i,
  input logic [PORT_W-1:0]        port_i,
  input logic [NUM_CH-1:0]        step_i,
  input logic                     ptr_hi_i,
  input logic [NUM_CH-1:0]        mask_i,
  input logic [NUM_CH*WORD_W-1:0] cur_count_i
);
  logic wr, chan_acc, ptr_clr, mask_touch;
  assign wr         = valid_i && write_i;
  assign chan_acc   = valid_i && !port_i[PORT_W-1];
  assign ptr_clr    = wr && (port_i == P_CLRPTR || port_i == P_MCLR);
  assign mask_touch = wr && (port_i == P_SMASK || port_i == P_MCLR ||
                             port_i == P_CLRMASK || port_i == P_AMASK);

  assert_ptr_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_acc |=> ptr_hi_i != $past(ptr_hi_i));

  assert_ptr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_acc && !ptr_clr) |=> $stable(ptr_hi_i));

  assert_ptr_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && port_i == P_CLRPTR) |=> !ptr_hi_i);

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_touch |=> $stable(mask_i));

  assert_mask_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && port_i == P_CLRMASK) |=> mask_i == '0);

  assert_mclr_masks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && port_i == P_MCLR) |=> mask_i == '1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
    logic hit;
    assign hit = wr && !port_i[PORT_W-1] && (port_i[CH_W:1] == CH_W'(g));
    assert_count_dec_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i[g] && !hit && cur_count_i[g*WORD_W +: WORD_W] != '0) |=>
      cur_count_i[g*WORD_W +: WORD_W] == $past(cur_count_i[g*WORD_W +: WORD_W]) - 1'b1);
  end
endmodule

bind dma_regfile dma_regfile_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (bus_valid_i),
  .write_i    (bus_write_i),
  .port_i     (bus_port_i),
  .step_i     (step_i),
  .ptr_hi_i   (ptr_hi),
  .mask_i     (chan_mask_o),
  .cur_count_i(cur_count_o)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_port = 4'h0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [3:0]  step = 4'h0;
  logic [23:0] chan_mode;
  logic [3:0]  chan_mask;
  logic [63:0] base_addr, base_count, cur_addr, cur_count;
  logic [7:0]  cmd;
  logic [3:0]  req;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_port_i(bus_port),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .step_i(step),
    .chan_mode_o(chan_mode), .chan_mask_o(chan_mask),
    .base_addr_o(base_addr), .base_count_o(base_count),
    .cur_addr_o(cur_addr), .cur_count_o(cur_count),
    .cmd_o(cmd), .req_o(req)
  );

  // behavioural reference
  logic [15:0] m_ba [4], m_bc [4], m_ca [4], m_cc [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  bit          m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; m_ptr = 0;
    end else begin
      automatic logic [3:0] newtc = 0;
      automatic bit wr = bus_valid && bus_write;
      automatic int ch = bus_port[2:1];
      automatic int sc = bus_wdata[1:0];
      automatic bit hi = m_ptr;
      for (int i = 0; i < 4; i++) begin
        automatic bit blk = wr && bus_port < 8 && ch == i;
        if (step[i] && !blk) begin
          if (m_cc[i] == 0) begin
            newtc[i] = 1'b1;
            if (m_mode[i][2]) begin m_ca[i] = m_ba[i]; m_cc[i] = m_bc[i]; end
            else begin
              m_cc[i] = 16'hFFFF;
              m_ca[i] = m_mode[i][3] ? m_ca[i] - 1 : m_ca[i] + 1;
            end
          end else begin
            m_cc[i] = m_cc[i] - 1;
            m_ca[i] = m_mode[i][3] ? m_ca[i] - 1 : m_ca[i] + 1;
          end
        end
      end
      if (wr) begin
        if (bus_port < 8) begin
          if (bus_port[0]) begin
            if (hi) m_bc[ch][15:8] = bus_wdata; else m_bc[ch][7:0] = bus_wdata;
            m_cc[ch] = m_bc[ch];
          end else begin
            if (hi) m_ba[ch][15:8] = bus_wdata; else m_ba[ch][7:0] = bus_wdata;
            m_ca[ch] = m_ba[ch];
          end
        end else begin
          case (bus_port)
            4'h8: m_cmd = bus_wdata;
            4'h9: m_req[sc] = bus_wdata[2];
            4'hA: m_mask[sc] = bus_wdata[2];
            4'hB: m_mode[sc] = bus_wdata[7:2];
            4'hD: begin m_mask = 4'hF; m_cmd = 0; m_req = 0; end
            4'hE: m_mask = 0;
            4'hF: m_mask = bus_wdata[3:0];
            default: ;
          endcase
        end
      end
      if (wr && (bus_port == 4'hC || bus_port == 4'hD)) m_ptr = 0;
      else if (bus_valid && bus_port < 8) m_ptr = ~m_ptr;
      if ((wr && bus_port == 4'hD) || (bus_valid && !bus_write && bus_port == 4'h8)) m_tc = 0;
      m_tc = m_tc | newtc;
    end
  end

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    logic [15:0] w;
    if (bus_port < 8) begin
      w = bus_port[0] ? m_cc[bus_port[2:1]] : m_ca[bus_port[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (bus_port == 4'h8) return {m_req, m_tc};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      check("R5", "mask", chan_mask, m_mask);
      check("R9", "cmd", cmd, m_cmd);
      check("R8", "req", req, m_req);
      for (int i = 0; i < 4; i++) begin
        check("R7", "mode", chan_mode[i*6 +: 6], m_mode[i]);
        check("R2", "base_addr", base_addr[i*16 +: 16], m_ba[i]);
        check("R2", "base_count", base_count[i*16 +: 16], m_bc[i]);
        check("R12", "cur_addr", cur_addr[i*16 +: 16], m_ca[i]);
        check("R12", "cur_count", cur_count[i*16 +: 16], m_cc[i]);
      end
      if (bus_port == 4'h8 || bus_port > 4'h8) check("R14", "rdata", bus_rdata, exp_rdata());
      else check("R11", "rdata", bus_rdata, exp_rdata());
    end
  end

  task automatic op(input bit w, input logic [3:0] p, input logic [7:0] d, input logic [3:0] s = 0);
    @(posedge clk); #1;
    bus_valid = 1; bus_write = w; bus_port = p; bus_wdata = d; step = s;
  endtask

  task automatic idle(input logic [3:0] s = 0);
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0; step = s;
  endtask

  task automatic load(input int ch, input logic [15:0] a, input logic [15:0] c);
    op(1, 4'hC, 8'h00);
    op(1, 4'(2*ch), a[7:0]);   op(1, 4'(2*ch), a[15:8]);
    op(1, 4'(2*ch+1), c[7:0]); op(1, 4'(2*ch+1), c[15:8]);
  endtask

  initial begin
    #(8*150000);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "reset mask", chan_mask, 4'hF);
    check("R1", "reset count", cur_count, 64'h0);
    check("R1", "reset rdata lo", bus_rdata, 8'h00);
    rst_n = 1;
    // R2 byte-order loads
    load(0, 16'h1234, 16'h0003);
    load(1, 16'h8000, 16'h0001);
    load(2, 16'h0010, 16'h0002);
    load(3, 16'hBEEF, 16'hCAFE);
    // R7 mode field
    op(1, 4'hB, 8'h48);
    op(1, 4'hB, 8'h44 | 8'h10 | 8'h01);
    op(1, 4'hB, 8'h44 | 8'h20 | 8'h02);
    op(1, 4'hB, 8'hC3);
    // R11 read back current words
    op(1, 4'hC, 8'h5A);
    for (int p = 0; p < 8; p++) begin op(0, 4'(p), 0); op(0, 4'(p), 0); end
    // R3 control access must not move the pointer
    op(0, 4'h0, 0); op(1, 4'h9, 8'h00); op(0, 4'h0, 0);
    // R4 clear pointer halfway
    op(0, 4'h2, 0); op(1, 4'hC, 8'hFF); op(0, 4'h2, 0);
    // R5 single mask, R6 clear/all mask
    op(1, 4'hA, 8'h00); op(1, 4'hA, 8'h01); op(1, 4'hA, 8'h06);
    op(1, 4'hE, 8'h00); op(1, 4'hF, 8'h05); op(1, 4'hF, 8'hFA);
    // R8 request, R9 command
    op(1, 4'h9, 8'h05); op(1, 4'h9, 8'h07); op(1, 4'h9, 8'h01);
    op(1, 4'h8, 8'hA5);
    // R12 count down through zero, R13 autoinit reload
    for (int k = 0; k < 4; k++) idle(4'h7);
    idle(4'h0);
    // R14 status read clears, coincident flag survives
    op(0, 4'h8, 0); op(0, 4'h8, 0);
    load(1, 16'h4000, 16'h0000);
    op(0, 4'h8, 0, 4'h2); op(0, 4'h8, 0); op(0, 4'hD, 0); op(0, 4'hF, 0);
    // R12 step cancelled by a coincident word write
    op(1, 4'hC, 0); op(1, 4'h6, 8'h11, 4'h8);
    // R10 master clear keeps modes and words
    op(1, 4'hD, 8'h00);
    op(0, 4'h8, 0);
    idle();
    // mixed pseudo-random phase
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom;
      automatic logic [3:0] p = 4'(r);
      if (p == 4'hD && r[9:8] != 0) p = 4'h3;
      if (r[4]) op(r[5], p, 8'(r >> 10), 4'(r >> 20));
      else idle(4'(r >> 20));
    end
    idle();
    idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule